// File: doc/BRIEF.md
# Timer Capture/Compare Channel Pair

This block holds two capture/compare channels that sit beside a shared up-counter. The counter is outside the block. Only its current value, a running qualifier and its MAX and ZERO pulses come in. Each channel owns one register, which works in one of two ways:

- **Capture mode.** The register takes a snapshot of the counter when a chosen edge of a chosen trigger occurs. The trigger is either an external pin or a level held by software. A sticky flag records that a capture happened.
- **Comparator mode.** The register is a compare value. The channel pulses MATCH when the running counter equals it. It also shapes a timer output from MATCH and the counter MAX/ZERO pulses.

A software trigger is produced by rewriting the trigger-source field between its "held low" and "held high" codes. This lets firmware force a capture without a pin. In comparator mode each channel may build its output from its own MATCH alone, or from its own MATCH together with its partner's. This allows waveforms that are set by one channel and cleared by the other.

Top module: `cc_pair`

## Requirements
- R1: After reset, both registers, both capture flags, both MATCH outputs and both timer outputs are 0.
- R2: Capture edge field (2 bits per channel): 0 = no capture, 1 = rising edge, 2 = falling edge, 3 = either edge. With trigger source 0 the external pin is the trigger. It passes two synchronising flops. A pin change first sampled at clock edge k loads the counter value sampled at edge k+2, visible after edge k+2.
- R3: Trigger source field (2 bits per channel): 0 = pin, 2 = software low, 3 = software high, 1 = no trigger. A change from 2 to 3 is a rising edge and a change from 3 to 2 is a falling edge. Either change also satisfies edge code 3. The capture loads the counter value at the clock edge that first samples the new source code. No other change of the source field triggers a capture.
- R4: The capture flag is set by every capture and stays set until a 1 is written to its clear input. A capture in the same cycle as a clear leaves the flag set.
- R5: In comparator mode (capture-mode bit 0), no pin or software trigger changes the register.
- R6: A write strobe loads the register from the write data in either mode. A capture in the same cycle takes precedence.
- R7: MATCH is registered. It is 1 in the cycle after a clock edge at which the channel is in comparator mode, the counter is running and the counter equals the register.
- R8: Output mode 0 (3-bit field) makes the timer output equal the software level bit sampled at the previous clock edge.
- R9: Output modes 1 and 2 set and clear the output on MATCH and on ZERO: mode 1 sets on MATCH and clears on ZERO, mode 2 clears on MATCH and sets on ZERO. Modes 6 and 7 do the same with MAX in place of ZERO: mode 6 sets on MATCH and clears on MAX, mode 7 clears on MATCH and sets on MAX. When MATCH and the MAX/ZERO event fall in the same cycle, the MAX/ZERO action wins.
- R10: Output mode 3 toggles the output on each MATCH.
- R11: Output mode 4 sets the output on the first MATCH and clears it on the second. Mode 5 is its inverse. With pair select 0 both come from the channel's own MATCH, so the output toggles. With pair select 1 the first is the own MATCH and the second is the partner's MATCH, and the own MATCH wins when both occur together.
- R12: With pair select 1, MATCH in modes 1, 2, 3, 6 and 7 is the OR of the channel's own MATCH and its partner's MATCH.
- R13: In capture mode, the output mode, pair select and software level have no effect: the timer output holds its value and MATCH stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntVal | input | 16 | Shared counter value |
| cntRun | input | 1 | Counter running |
| cntMax | input | 1 | Counter MAX pulse |
| cntZero | input | 1 | Counter ZERO pulse |
| capMode | input | 2 | Per channel: 1 = capture, 0 = comparator |
| edgeSel | input | 4 | Per channel capture edge field, channel i at [2i+1:2i] |
| trigSrc | input | 4 | Per channel trigger source field |
| outMode | input | 6 | Per channel output mode field, channel i at [3i+2:3i] |
| outPair | input | 2 | Per channel pair select |
| swLevel | input | 2 | Per channel software output level |
| capPin | input | 2 | External capture pins |
| cmpWe | input | 2 | Per channel register write strobe |
| cmpData | input | 16 | Register write data |
| flagClr | input | 2 | Per channel write-1 flag clear |
| ccReg | output | 32 | Channel registers, channel i at [16i+15:16i] |
| capFlag | output | 2 | Sticky capture flags |
| match | output | 2 | Registered MATCH pulses |
| tout | output | 2 | Timer outputs |

## Verification
Two pairs of events can land in the same cycle:

- **MATCH with a counter event.** A channel's MATCH can coincide with the counter's MAX or ZERO pulse. Both also share a cycle with the partner's MATCH when the two compare values are equal.
- **Capture with a register operation.** A capture can coincide with a register write or a flag clear.

The random stimulus provokes these collisions deliberately. Counter values and compare values are drawn from a tiny range, so matches are frequent. MAX/ZERO pulses, writes and clears are scattered at random. A directed case puts a MATCH and a ZERO in one cycle and expects the output to be cleared. Every cycle, each channel's output is judged against a bench model that applies the stated precedence: counter event over MATCH, own MATCH over partner MATCH, capture over write, set over clear.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int NCH = 2;

  typedef struct packed {
    logic capLoad;
    logic cmpLoad;
    logic flagClr;
  } ccStrobe_t;

  typedef enum logic [1:0] {
    SRC_PIN  = 2'd0,
    SRC_NONE = 2'd1,
    SRC_LOW  = 2'd2,
    SRC_HIGH = 2'd3
  } trigSrc_e;

  typedef enum logic [2:0] {
    OM_SW     = 3'd0,
    OM_SET_Z  = 3'd1,
    OM_CLR_Z  = 3'd2,
    OM_TOG    = 3'd3,
    OM_DUAL   = 3'd4,
    OM_DUALN  = 3'd5,
    OM_SET_MX = 3'd6,
    OM_CLR_MX = 3'd7
  } outMode_e;
endpackage

// File: rtl/cc_ctrl.sv
module cc_ctrl
  import cc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCH-1:0]        capMode,
  input  logic [2*NCH-1:0]      edgeSel,
  input  logic [2*NCH-1:0]      trigSrc,
  input  logic [NCH-1:0]        capPin,
  input  logic [NCH-1:0]        cmpWe,
  input  logic [NCH-1:0]        flagClr,
  output ccStrobe_t [NCH-1:0]   stb
);
  localparam int TOP = SYNC_STAGES - 1;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [SYNC_STAGES-1:0] pinSync;
    logic                   pinLast;
    logic [1:0]             srcPrev;
    logic [1:0]             src;
    logic [1:0]             edgeCode;
    logic                   pinRise, pinFall, swRise, swFall;

    assign src      = trigSrc[2*i +: 2];
    assign edgeCode = edgeSel[2*i +: 2];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pinSync <= '0;
        pinLast <= 1'b0;
        srcPrev <= 2'd0;
      end else begin
        pinSync <= {pinSync[SYNC_STAGES-2:0], capPin[i]};
        pinLast <= pinSync[TOP];
        srcPrev <= src;
      end
    end

    assign pinRise = pinSync[TOP] & ~pinLast;
    assign pinFall = ~pinSync[TOP] & pinLast;
    assign swRise  = (srcPrev == SRC_LOW) && (src == SRC_HIGH);
    assign swFall  = (srcPrev == SRC_HIGH) && (src == SRC_LOW);

    always_comb begin
      stb[i].capLoad = capMode[i] &
        (((src == SRC_PIN) & ((pinRise & edgeCode[0]) | (pinFall & edgeCode[1]))) |
         (swRise & edgeCode[0]) | (swFall & edgeCode[1]));
      stb[i].cmpLoad = cmpWe[i];
      stb[i].flagClr = flagClr[i];
    end
  end
endmodule

// File: rtl/cc_datapath.sv
module cc_datapath
  import cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ccStrobe_t [NCH-1:0]   stb,
  input  logic [CNT_W-1:0]      cntVal,
  input  logic                  cntRun,
  input  logic                  cntMax,
  input  logic                  cntZero,
  input  logic [CNT_W-1:0]      cmpData,
  input  logic [NCH-1:0]        capMode,
  input  logic [3*NCH-1:0]      outMode,
  input  logic [NCH-1:0]        outPair,
  input  logic [NCH-1:0]        swLevel,
  output logic [NCH*CNT_W-1:0]  ccReg,
  output logic [NCH-1:0]        capFlag,
  output logic [NCH-1:0]        match,
  output logic [NCH-1:0]        tout
);
  logic [NCH-1:0] hit;

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign hit[i] = ~capMode[i] & cntRun & (cntVal == ccReg[CNT_W*i +: CNT_W]);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int P = i ^ 1;
    logic     anyHit;
    logic     toutNext;
    outMode_e mode;

    assign mode   = outMode_e'(outMode[3*i +: 3]);
    assign anyHit = hit[i] | (outPair[i] & hit[P]);

    always_comb begin
      toutNext = tout[i];
      unique case (mode)
        OM_SW:     toutNext = swLevel[i];
        OM_SET_Z:  if (cntZero) toutNext = 1'b0; else if (anyHit) toutNext = 1'b1;
        OM_CLR_Z:  if (cntZero) toutNext = 1'b1; else if (anyHit) toutNext = 1'b0;
        OM_TOG:    if (anyHit) toutNext = ~tout[i];
        OM_DUAL:   if (!outPair[i]) begin
                     if (hit[i]) toutNext = ~tout[i];
                   end else if (hit[i]) toutNext = 1'b1;
                   else if (hit[P]) toutNext = 1'b0;
        OM_DUALN:  if (!outPair[i]) begin
                     if (hit[i]) toutNext = ~tout[i];
                   end else if (hit[i]) toutNext = 1'b0;
                   else if (hit[P]) toutNext = 1'b1;
        OM_SET_MX: if (cntMax) toutNext = 1'b0; else if (anyHit) toutNext = 1'b1;
        OM_CLR_MX: if (cntMax) toutNext = 1'b1; else if (anyHit) toutNext = 1'b0;
        default:   toutNext = tout[i];
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ccReg[CNT_W*i +: CNT_W] <= '0;
        capFlag[i]              <= 1'b0;
        match[i]                <= 1'b0;
        tout[i]                 <= 1'b0;
      end else begin
        if (stb[i].capLoad)      ccReg[CNT_W*i +: CNT_W] <= cntVal;
        else if (stb[i].cmpLoad) ccReg[CNT_W*i +: CNT_W] <= cmpData;
        if (stb[i].capLoad)      capFlag[i] <= 1'b1;
        else if (stb[i].flagClr) capFlag[i] <= 1'b0;
        match[i] <= hit[i];
        if (!capMode[i]) tout[i] <= toutNext;
      end
    end
  end
endmodule

// File: rtl/cc_pair.sv
module cc_pair
  import cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CNT_W-1:0]      cntVal,
  input  logic                  cntRun,
  input  logic                  cntMax,
  input  logic                  cntZero,
  input  logic [NCH-1:0]        capMode,
  input  logic [2*NCH-1:0]      edgeSel,
  input  logic [2*NCH-1:0]      trigSrc,
  input  logic [3*NCH-1:0]      outMode,
  input  logic [NCH-1:0]        outPair,
  input  logic [NCH-1:0]        swLevel,
  input  logic [NCH-1:0]        capPin,
  input  logic [NCH-1:0]        cmpWe,
  input  logic [CNT_W-1:0]      cmpData,
  input  logic [NCH-1:0]        flagClr,
  output logic [NCH*CNT_W-1:0]  ccReg,
  output logic [NCH-1:0]        capFlag,
  output logic [NCH-1:0]        match,
  output logic [NCH-1:0]        tout
);
  ccStrobe_t [NCH-1:0] stb;

  cc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .capMode(capMode), .edgeSel(edgeSel),
    .trigSrc(trigSrc), .capPin(capPin), .cmpWe(cmpWe), .flagClr(flagClr),
    .stb(stb)
  );

  cc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cntVal(cntVal), .cntRun(cntRun),
    .cntMax(cntMax), .cntZero(cntZero), .cmpData(cmpData), .capMode(capMode),
    .outMode(outMode), .outPair(outPair), .swLevel(swLevel), .ccReg(ccReg),
    .capFlag(capFlag), .match(match), .tout(tout)
  );
endmodule

// File: rtl/cc_pair_chk.sv
module cc_pair_chk
  import cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cntZero,
  input logic [NCH-1:0]       capMode,
  input logic [3*NCH-1:0]     outMode,
  input logic [NCH-1:0]       swLevel,
  input logic [NCH-1:0]       cmpWe,
  input logic [NCH-1:0]       flagClr,
  input logic [NCH*CNT_W-1:0] ccReg,
  input logic [NCH-1:0]       capFlag,
  input logic [NCH-1:0]       match,
  input logic [NCH-1:0]       tout
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (capFlag[i] && !flagClr[i]) |=> capFlag[i]); // R4
    AST_CMP_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
      (!capMode[i] && !cmpWe[i]) |=> $stable(ccReg[CNT_W*i +: CNT_W])); // R5
    AST_SW_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
      (!capMode[i] && outMode[3*i +: 3] == 3'd0) |=> (tout[i] == $past(swLevel[i]))); // R8
    AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (!capMode[i] && outMode[3*i +: 3] == 3'd1 && cntZero) |=> !tout[i]); // R9
    AST_CAP_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rstN)
      capMode[i] |=> ($stable(tout[i]) && !match[i])); // R13
  end
endmodule

bind cc_pair cc_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cntZero(cntZero), .capMode(capMode),
  .outMode(outMode), .swLevel(swLevel), .cmpWe(cmpWe), .flagClr(flagClr),
  .ccReg(ccReg), .capFlag(capFlag), .match(match), .tout(tout)
);

// File: tb/tb_cc_pair.sv
`timescale 1ns/1ps
module tb_cc_pair;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cntVal = '0;
  logic        cntRun = 1'b0, cntMax = 1'b0, cntZero = 1'b0;
  logic [1:0]  capMode = '0, outPair = '0, swLevel = '0, capPin = '0;
  logic [1:0]  cmpWe = '0, flagClr = '0;
  logic [3:0]  edgeSel = '0, trigSrc = '0;
  logic [5:0]  outMode = '0;
  logic [15:0] cmpData = '0;
  logic [31:0] ccReg;
  logic [1:0]  capFlag, match, tout;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // bench model state (after the next edge)
  logic [15:0] mReg [2];
  logic        mFlag[2], mMatch[2], mTout[2];
  logic        d1[2], d2[2], d3[2];
  logic [1:0]  mPrev[2];

  cc_pair dut (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .cntRun(cntRun), .cntMax(cntMax),
    .cntZero(cntZero), .capMode(capMode), .edgeSel(edgeSel), .trigSrc(trigSrc),
    .outMode(outMode), .outPair(outPair), .swLevel(swLevel), .capPin(capPin),
    .cmpWe(cmpWe), .cmpData(cmpData), .flagClr(flagClr), .ccReg(ccReg),
    .capFlag(capFlag), .match(match), .tout(tout)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic nextOut(int i, logic h0, logic h1);
    logic own, oth, any, t;
    own = i == 0 ? h0 : h1;
    oth = i == 0 ? h1 : h0;
    any = own | (outPair[i] & oth);
    t = mTout[i];
    case (outMode[3*i +: 3])
      3'd0: return swLevel[i];
      3'd1: return cntZero ? 1'b0 : (any ? 1'b1 : t);
      3'd2: return cntZero ? 1'b1 : (any ? 1'b0 : t);
      3'd3: return any ? ~t : t;
      3'd4: return !outPair[i] ? (own ? ~t : t) : (own ? 1'b1 : (oth ? 1'b0 : t));
      3'd5: return !outPair[i] ? (own ? ~t : t) : (own ? 1'b0 : (oth ? 1'b1 : t));
      3'd6: return cntMax ? 1'b0 : (any ? 1'b1 : t);
      default: return cntMax ? 1'b1 : (any ? 1'b0 : t);
    endcase
  endfunction

  task automatic modelStep();
    logic h[2];
    logic trig, pr, pf, sr, sf;
    logic [1:0] src, ed;
    for (int i = 0; i < 2; i++)
      h[i] = !capMode[i] && cntRun && cntVal == mReg[i];
    for (int i = 0; i < 2; i++) begin
      src = trigSrc[2*i +: 2];
      ed  = edgeSel[2*i +: 2];
      pr = d2[i] && !d3[i];
      pf = !d2[i] && d3[i];
      sr = mPrev[i] == 2'd2 && src == 2'd3;
      sf = mPrev[i] == 2'd3 && src == 2'd2;
      trig = capMode[i] && ((src == 2'd0 && ((pr && ed[0]) || (pf && ed[1]))) ||
                            (sr && ed[0]) || (sf && ed[1]));
      if (!capMode[i]) mTout[i] = nextOut(i, h[0], h[1]);
      if (trig) mReg[i] = cntVal;
      else if (cmpWe[i]) mReg[i] = cmpData;
      mFlag[i] = trig | (mFlag[i] & !flagClr[i]);
      mMatch[i] = h[i];
      d3[i] = d2[i]; d2[i] = d1[i]; d1[i] = capPin[i];
      mPrev[i] = src;
    end
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk("R2/R3/R5/R6 register", ccReg[16*i +: 16], mReg[i]);
      chk("R4 flag", {15'd0, capFlag[i]}, {15'd0, mFlag[i]});
      chk("R7/R13 match", {15'd0, match[i]}, {15'd0, mMatch[i]});
      chk("R8/R9/R10/R11/R12/R13 output", {15'd0, tout[i]}, {15'd0, mTout[i]});
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 2; i++) begin
      mReg[i] = '0; mFlag[i] = 0; mMatch[i] = 0; mTout[i] = 0;
      d1[i] = 0; d2[i] = 0; d3[i] = 0; mPrev[i] = 2'd0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 reg", ccReg[15:0], 16'h0);
    chk("R1 reg", ccReg[31:16], 16'h0);
    chk("R1 flag/match/out", {10'd0, capFlag, match, tout}, 16'h0);

    // R3 software rising trigger on channel 0
    capMode = 2'b01; edgeSel = 4'b0001; trigSrc = 4'b0010; cntVal = 16'h1234;
    tick();
    trigSrc = 4'b0011;
    tick();
    chk("R3 sw rise capture", ccReg[15:0], 16'h1234);
    chk("R3 flag set", {15'd0, capFlag[0]}, 16'h1);
    trigSrc = 4'b0010; cntVal = 16'h2222;
    tick();
    chk("R3 falling ignored with rise code", ccReg[15:0], 16'h1234);
    flagClr = 2'b01;
    tick();
    flagClr = 2'b00;
    chk("R4 flag cleared", {15'd0, capFlag[0]}, 16'h0);

    // R2 pin falling edge, latency through the synchroniser
    trigSrc = 4'b0000; edgeSel = 4'b0010; capPin = 2'b01;
    repeat (4) tick();
    chk("R2 rising ignored with fall code", ccReg[15:0], 16'h1234);
    capPin = 2'b00; cntVal = 16'h0055;
    tick(); tick();
    chk("R2 not yet captured", ccReg[15:0], 16'h1234);
    tick();
    chk("R2 pin capture", ccReg[15:0], 16'h0055);

    // R5 triggers ignored on channel 1 in comparator mode; R9 zero wins
    cmpWe = 2'b10; cmpData = 16'd5;
    tick();
    cmpWe = 2'b00; edgeSel = 4'b1100; trigSrc = 4'b1000;
    tick();
    trigSrc = 4'b1100;
    tick();
    chk("R5 compare reg kept", ccReg[31:16], 16'd5);
    outMode = 6'b001_000; cntRun = 1'b1; cntVal = 16'd5; cntZero = 1'b1;
    tick();
    chk("R9 zero beats match", {15'd0, tout[1]}, 16'h0);
    chk("R7 match pulse", {15'd0, match[1]}, 16'h1);
    cntZero = 1'b0;
    tick();
    chk("R9 set on match", {15'd0, tout[1]}, 16'h1);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 16 == 0) capMode = 2'($urandom);
      if ($urandom % 4 == 0) edgeSel = 4'($urandom);
      if ($urandom % 4 == 0) trigSrc = 4'($urandom);
      if ($urandom % 32 == 0) outMode = 6'($urandom);
      if ($urandom % 16 == 0) outPair = 2'($urandom);
      swLevel = 2'($urandom);
      if ($urandom % 4 == 0) capPin = 2'($urandom);
      cntVal  = 16'($urandom % 8);
      cntRun  = ($urandom % 4) != 0;
      cntMax  = ($urandom % 8) == 0;
      cntZero = ($urandom % 8) == 0;
      cmpWe   = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      cmpData = 16'($urandom % 8);
      flagClr = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      tick();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule